// File: doc/BRIEF.md
# Host-Side Shared Message Memory Port

This block is the host-facing side of a 16-bit message memory that a communication controller shares with an application processor. The host presents an 11-bit word address, write data and three active-low strobes: select, write and output enable. None of these has any timing relation to the controller clock. Every host input passes through a two-stage synchroniser. A falling edge on the synchronised select starts one access. The block then counts controller clock cycles to confirm that the host held its signals long enough, performs the read or write on a 1024-word internal memory, and pulls an active-low ready output. Ready stays low until the host releases select.

A read result is kept in a read buffer. The host's output enable does not start an access. It only asks for the buffer to be driven. The block presents the buffer value together with a drive-enable flag, and the pad logic outside the block builds the tristate bus from the two. If an access breaks a minimum hold rule, the block drops it and sets a sticky error flag. A second, synchronous port gives the controller side direct read and write access to the same words. When both sides write the same word in the same cycle, the controller's write is the one kept.

Top module: `hostport_dpram`

## Requirements
- R1: After reset, ready (`h_rdy_n`) is high, the error flag is low, the drive enable is low and the read buffer (`h_dq_out`) is zero.
- R2: A host write (write strobe low when select falls) stores the write data at the address. Ready falls at the 5th rising clock edge, counting the first edge at which select is low as the 1st.
- R3: A host read (write strobe high when select falls) loads the addressed word into the read buffer. Ready falls at the 8th rising edge, counted the same way as in R2.
- R4: Ready stays low for as long as select is held low. It returns high at the 3rd rising edge after select rises.
- R5: If select is low for fewer than 2 clock cycles, the access is dropped: no write, no ready. The error flag is then set.
- R6: If the address, the write strobe or (for a write) the write data changes within 3 clock cycles of select falling, the access is dropped and the error flag is set. Signals held for exactly 3 cycles are accepted.
- R7: The error flag stays set, and accesses keep working, until the next reset.
- R8: The drive enable (`h_dq_oe`) follows the inverted output enable through a two-stage synchroniser. It rises at the 2nd rising edge after output enable falls, while `h_dq_out` shows the result of the last completed host read.
- R9: The controller port writes at the clock edge where `c_en` and `c_we` are both high. A read (`c_en` high, `c_we` low) returns the word on `c_rdata` after the following edge.
- R10: When a host write and a controller write target the same word at the same edge, the controller's data is stored.
- R11: A host address with bit 10 set lies outside the 1024-word memory. A write there changes no word but still completes with ready. A read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset |
| h_addr | input | 11 | Host word address |
| h_wdata | input | 16 | Host write data |
| h_cs_n | input | 1 | Host select, active low |
| h_we_n | input | 1 | Host write strobe, active low |
| h_oe_n | input | 1 | Host output enable, active low |
| h_rdy_n | output | 1 | Access finished, active low |
| h_err | output | 1 | Sticky hold-violation flag |
| h_dq_out | output | 16 | Read buffer toward the host bus |
| h_dq_oe | output | 1 | Drive request for the host bus |
| c_en | input | 1 | Controller access enable |
| c_we | input | 1 | Controller write select |
| c_addr | input | 10 | Controller word address |
| c_wdata | input | 16 | Controller write data |
| c_rdata | output | 16 | Controller read data |

## Verification
Faults in the access state machine or in the hold counter show up at the ports, on ready, as a fall that comes an edge early or late, a missing fall, or a fall on an access that should have been dropped. The scoreboard therefore checks the exact ready latency of every host access. It also flags any ready fall for which no access was expected. A wrong latched address or data word stays hidden until a later read of that word, so each write is followed by a read-back through the other port or the same port. The error flag is checked both in the cycle after a bad access and again after later good accesses.

// File: rtl/hostport_dpram.sv
module hostport_dpram #(
  parameter int AW       = 11,
  parameter int DW       = 16,
  parameter int DEPTH    = 1024,
  parameter int CE_MIN   = 2,
  parameter int HOLD_MIN = 3,
  parameter int RD_LAT   = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [AW-1:0]            h_addr,
  input  logic [DW-1:0]            h_wdata,
  input  logic                     h_cs_n,
  input  logic                     h_we_n,
  input  logic                     h_oe_n,
  output logic                     h_rdy_n,
  output logic                     h_err,
  output logic [DW-1:0]            h_dq_out,
  output logic                     h_dq_oe,
  input  logic                     c_en,
  input  logic                     c_we,
  input  logic [$clog2(DEPTH)-1:0] c_addr,
  input  logic [DW-1:0]            c_wdata,
  output logic [DW-1:0]            c_rdata
);
  localparam int MW = $clog2(DEPTH);
  localparam int CW = $clog2(RD_LAT + 1);
  localparam int SW = AW + 1 + DW;
  localparam logic [AW:0] DEPTH_X = (AW+1)'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_DONE, S_WAIT} st_t;

  logic [SW-1:0] f1, f2;
  logic [2:0]    cs_sh;
  logic [1:0]    oe_sh;
  st_t           st;
  logic [CW-1:0] cnt;
  logic          l_we_n;
  logic [AW-1:0] l_addr;
  logic [DW-1:0] l_wd;
  logic [DW-1:0] rbuf;
  logic [DW-1:0] mem [DEPTH];

  wire          cs_s    = cs_sh[1];
  wire          cs_fall = !cs_sh[1] && cs_sh[2];
  wire          s_we_n  = f2[SW-1];
  wire [AW-1:0] s_addr  = f2[SW-2 -: AW];
  wire [DW-1:0] s_wd    = f2[DW-1:0];
  wire          in_rng  = {1'b0, l_addr} < DEPTH_X;

  wire mismatch  = (s_addr != l_addr) || (s_we_n != l_we_n) || (!l_we_n && (s_wd != l_wd));
  wire bad       = (cs_s && (cnt < CW'(CE_MIN))) || (mismatch && (cnt < CW'(HOLD_MIN)));
  wire commit_wr = (st == S_ACT) && !bad && !l_we_n && (cnt == CW'(HOLD_MIN - 1));
  wire commit_rd = (st == S_ACT) && !bad &&  l_we_n && (cnt == CW'(RD_LAT - 1));
  wire host_wr   = commit_wr && in_rng;

  assign h_dq_out = rbuf;
  assign h_dq_oe  = !oe_sh[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1    <= '1;
      f2    <= '1;
      cs_sh <= '1;
      oe_sh <= '1;
    end else begin
      f1    <= {h_we_n, h_addr, h_wdata};
      f2    <= f1;
      cs_sh <= {cs_sh[1], cs_sh[0], h_cs_n};
      oe_sh <= {oe_sh[0], h_oe_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      h_rdy_n <= 1'b1;
      h_err   <= 1'b0;
      rbuf    <= '0;
      l_we_n  <= 1'b1;
      l_addr  <= '0;
      l_wd    <= '0;
    end else begin
      case (st)
        S_IDLE: if (cs_fall) begin
          st     <= S_ACT;
          cnt    <= CW'(1);
          l_we_n <= s_we_n;
          l_addr <= s_addr;
          l_wd   <= s_wd;
        end
        S_ACT: begin
          if (bad) begin
            h_err <= 1'b1;
            st    <= S_WAIT;
          end else if (commit_wr || commit_rd) begin
            h_rdy_n <= 1'b0;
            st      <= S_DONE;
            if (commit_rd) rbuf <= in_rng ? mem[l_addr[MW-1:0]] : '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        S_DONE: if (cs_s) begin
          h_rdy_n <= 1'b1;
          st      <= S_IDLE;
        end
        default: if (cs_s) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (host_wr) mem[l_addr[MW-1:0]] <= l_wd;
    if (c_en && c_we) mem[c_addr] <= c_wdata;
    if (c_en && !c_we) c_rdata <= mem[c_addr];
  end

  // R5 R6
  drop_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(h_err) |-> h_rdy_n);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_err |=> h_err);
  // R4
  rdy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!h_rdy_n && cs_s) |=> h_rdy_n);
  // R3
  rbuf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_rdy_n |-> $stable(rbuf));
  // R2
  rdy_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(h_rdy_n) |-> ($past(st) == S_ACT));
  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT) |-> (cnt < CW'(RD_LAT)));
endmodule

// File: tb/hostport_dpram_test.sv
`timescale 1ns/1ps
module hostport_dpram_test;
  logic        clk = 0, rst_n = 0;
  logic [10:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic        h_cs_n = 1, h_we_n = 1, h_oe_n = 1;
  logic        h_rdy_n, h_err, h_dq_oe;
  logic [15:0] h_dq_out, c_rdata;
  logic        c_en = 0, c_we = 0;
  logic [9:0]  c_addr = '0;
  logic [15:0] c_wdata = '0;

  hostport_dpram uut (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata),
    .h_cs_n(h_cs_n), .h_we_n(h_we_n), .h_oe_n(h_oe_n), .h_rdy_n(h_rdy_n),
    .h_err(h_err), .h_dq_out(h_dq_out), .h_dq_oe(h_dq_oe), .c_en(c_en),
    .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata), .c_rdata(c_rdata)
  );

  always #4 clk = ~clk;

  typedef struct { bit rd; logic [15:0] d; int lat; string req; } item_t;
  item_t exp_q[$];
  int total = 0, bad = 0, cyc = 0, t0 = 0;
  logic prev_rdy = 1;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compare each ready fall with the oldest expected access
  always @(negedge clk) begin
    if (rst_n && prev_rdy && !h_rdy_n) begin
      if (exp_q.size() == 0) chk(0, "R5/R6 unexpected ready", 1, 0);
      else begin
        item_t it;
        it = exp_q.pop_front();
        chk(cyc - t0 == it.lat, it.req, cyc - t0, it.lat);
        if (it.rd) chk(h_dq_out == it.d, it.req, h_dq_out, it.d);
      end
    end
    prev_rdy = h_rdy_n;
  end

  task automatic host_acc(input bit rd, input [10:0] a, input [15:0] d, input int cs_len,
                          input int fld_len, input bit ok, input [15:0] ed, input string req);
    int n;
    n = (cs_len > fld_len) ? cs_len : fld_len;
    @(negedge clk);
    h_addr = a; h_wdata = d; h_we_n = rd; h_cs_n = 0; t0 = cyc;
    if (ok) exp_q.push_back('{rd, ed, rd ? 8 : 5, req});
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == cs_len) h_cs_n = 1;
      if (i == fld_len) begin h_addr = ~a; h_wdata = ~d; end
    end
    h_cs_n = 1; h_we_n = 1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hwr(input [10:0] a, input [15:0] d, input string req);
    host_acc(0, a, d, 10, 10, 1, 16'h0, req);
  endtask
  task automatic hrd(input [10:0] a, input [15:0] ed, input string req);
    host_acc(1, a, 16'h0, 10, 10, 1, ed, req);
  endtask
  task automatic cwr(input [9:0] a, input [15:0] d);
    @(negedge clk); c_en = 1; c_we = 1; c_addr = a; c_wdata = d;
    @(negedge clk); c_en = 0; c_we = 0;
  endtask
  task automatic crd(input [9:0] a, input [15:0] ed, input string req);
    @(negedge clk); c_en = 1; c_we = 0; c_addr = a;
    @(negedge clk); c_en = 0;
    chk(c_rdata == ed, req, c_rdata, ed);
  endtask
  task automatic do_reset();
    rst_n = 0; h_cs_n = 1; h_oe_n = 1; c_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 20000);
    chk(0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk(h_rdy_n == 1, "R1 ready", h_rdy_n, 1);
    chk(h_err == 0, "R1 error", h_err, 0);
    chk(h_dq_oe == 0, "R1 drive", h_dq_oe, 0);
    chk(h_dq_out == 0, "R1 buffer", h_dq_out, 0);

    hwr(11'h005, 16'hA5C3, "R2 write latency");
    hrd(11'h005, 16'hA5C3, "R3 read");
    hwr(11'h3FF, 16'h1234, "R2 write top word");
    hrd(11'h3FF, 16'h1234, "R3 read top word");

    cwr(10'h010, 16'hBEEF);
    hrd(11'h010, 16'hBEEF, "R9 ctrl write host read");
    hwr(11'h020, 16'hCAFE, "R2 write");
    crd(10'h020, 16'hCAFE, "R9 host write ctrl read");

    // R8 output enable
    @(negedge clk); h_oe_n = 0;
    @(negedge clk); chk(h_dq_oe == 0, "R8 drive after 1 edge", h_dq_oe, 0);
    @(negedge clk); chk(h_dq_oe == 1, "R8 drive after 2 edges", h_dq_oe, 1);
    chk(h_dq_out == 16'hBEEF, "R8 last read", h_dq_out, 16'hBEEF);
    h_oe_n = 1;
    repeat (2) @(negedge clk);
    chk(h_dq_oe == 0, "R8 drive off", h_dq_oe, 0);

    // R4 ready held while select low
    @(negedge clk);
    h_addr = 11'h030; h_wdata = 16'h0F0F; h_we_n = 0; h_cs_n = 0; t0 = cyc;
    exp_q.push_back('{0, 16'h0, 5, "R4 write"});
    repeat (12) @(negedge clk);
    chk(h_rdy_n == 0, "R4 held low", h_rdy_n, 0);
    h_cs_n = 1; h_we_n = 1;
    repeat (2) @(negedge clk);
    chk(h_rdy_n == 0, "R4 low 2 edges after rise", h_rdy_n, 0);
    @(negedge clk);
    chk(h_rdy_n == 1, "R4 high 3 edges after rise", h_rdy_n, 1);
    repeat (4) @(negedge clk);
    hrd(11'h030, 16'h0F0F, "R4 readback");

    // R10 same-word collision
    fork
      hwr(11'h040, 16'h1111, "R10 host write");
      begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        c_en = 1; c_we = 1; c_addr = 10'h040; c_wdata = 16'h2222;
        @(negedge clk); c_en = 0; c_we = 0;
      end
    join
    hrd(11'h040, 16'h2222, "R10 controller wins");

    // R11 out of range
    cwr(10'h000, 16'h0101);
    hwr(11'h400, 16'h9999, "R11 write completes");
    hrd(11'h000, 16'h0101, "R11 no alias write");
    hrd(11'h400, 16'h0000, "R11 read zero");

    // R5 short select
    cwr(10'h050, 16'h5555);
    host_acc(0, 11'h050, 16'hAAAA, 1, 10, 0, 16'h0, "R5");
    chk(h_err == 1, "R5 error set", h_err, 1);
    hrd(11'h050, 16'h5555, "R5 dropped write");
    chk(h_err == 1, "R7 sticky", h_err, 1);

    do_reset();
    chk(h_err == 0, "R7 cleared by reset", h_err, 0);

    // R6 hold violations
    hwr(11'h061, 16'h3333, "R6 setup");
    host_acc(0, 11'h061, 16'h4444, 10, 3, 1, 16'h0, "R6 exact hold");
    chk(h_err == 0, "R6 exact hold no error", h_err, 0);
    hrd(11'h061, 16'h4444, "R6 exact hold stored");
    cwr(10'h060, 16'h6666);
    host_acc(0, 11'h060, 16'h7777, 10, 2, 0, 16'h0, "R6");
    chk(h_err == 1, "R6 error set", h_err, 1);
    hrd(11'h060, 16'h6666, "R6 dropped write");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2/R3 pending accesses", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule